// File: doc/BRIEF.md
# Dual-Sample Timing Error Detector

This block is a pipeline register of configurable width that can tell when its own contents are wrong. A primary register takes the combinational result on the rising edge of the main clock, and this value drives the data output. A second register, the shadow copy, takes the same input on the rising edge of a delayed clock. The delayed clock is a phase-shifted copy of the main clock and is supplied from outside the block. The offset must be larger than the worst critical-path delay and larger than the longest glitch a particle strike can cause. With that offset, at least one of the two copies always holds the correct value.

A comparator checks the two copies. Its result is registered on the next main edge, so a mismatch appears on the error output one main cycle after the bad capture. The condition is a transition that arrived too late for the main edge, a short pulse that only one copy saw, or an upset that flipped either copy directly. Correction and pipeline control are left to the surrounding logic, which reacts to the error output.

After reset, the first main edge is never compared. Between reset release and that edge, the shadow copy may already have sampled live data while the primary copy still holds zero, and that difference is not an error.

Top module: `shadow_reg_check`

## Requirements
- R1: On each rising edge of `clk_main` the primary register loads `d_in`, and `q_out` shows that value until the next main edge.
- R2: The shadow register loads `d_in` on each rising edge of `clk_late`. A change of `d_in` after a main edge and before the following delayed edge sets `err_flag` high during the next main cycle.
- R3: A pulse on `d_in` that the main edge captures but that has gone before the delayed edge sets `err_flag` high during the next main cycle.
- R4: A bit flipped directly in the primary register sets `err_flag` high in the main cycle after the next main edge.
- R5: A bit flipped directly in the shadow register sets `err_flag` high in the main cycle after the next main edge.
- R6: `err_flag` is a registered output. It stays high for exactly one main cycle for each mismatching capture pair, and it stays low when both copies captured the same value, including a late transition to an unchanged value.
- R7: While `rst_n` is low (active-low, asynchronous), the primary register, the shadow register and `err_flag` are all zero.
- R8: The first main edge after `rst_n` rises raises no error, even when the shadow copy already sampled a nonzero input before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock; the primary register samples on its rising edge |
| clk_late | input | 1 | Delayed copy of the main clock; the shadow register samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | WIDTH | Combinational result to be registered |
| q_out | output | WIDTH | Primary register contents |
| err_flag | output | 1 | High for one main cycle after a mismatch between the two copies |

## Verification
On every cycle, the embedded properties check three things: the cleared state under reset, the silence of the flag on the first cycles after release, and that any primary value differing from the previously presented input is followed by a flag. Only the bench's scenarios can show the rest. These are the late arrivals placed between the two clock edges, the glitch straddling a main edge, the injected flips in the shadow copy, the one-cycle width of the flag, and the absence of a flag when a late transition leaves the value unchanged. All of these depend on when the stimulus lands relative to the delayed edge, which no single-clock property sees.

// File: rtl/shadow_reg_check.sv
`timescale 1ns/1ps
module shadow_reg_check #(
  parameter int WIDTH = 8
) (
  input  logic             clk_main,
  input  logic             clk_late,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out,
  output logic             err_flag
);

  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] shadow_q;
  logic             armed;
  logic             err_q;

  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n) main_q <= '0;
    else        main_q <= d_in;

  always_ff @(posedge clk_late or negedge rst_n)
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= d_in;

  // first main edge after reset compares a half-loaded pair: mask it
  always_ff @(posedge clk_main or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      err_q <= 1'b0;
    end else begin
      armed <= 1'b1;
      err_q <= armed && (main_q != shadow_q);
    end

  assign q_out    = main_q;
  assign err_flag = err_q;

  assert_reset_flag_R7: assert property (@(posedge clk_main)
    !rst_n |=> !err_flag);

  assert_reset_data_R7: assert property (@(posedge clk_main)
    !rst_n |=> (q_out == '0));

  assert_quiet_after_reset_R8: assert property (@(posedge clk_main) disable iff (!rst_n)
    err_flag |-> $past(rst_n, 2));

  assert_main_upset_flagged_R4: assert property (@(posedge clk_main) disable iff (!rst_n)
    ($past(rst_n) && (q_out != $past(d_in))) |=> err_flag);

endmodule

// File: tb/shadow_reg_check_bench.sv
`timescale 1ns/1ps
module shadow_reg_check_bench;
  localparam int W = 8;
  localparam int NV = 12;
  // entry = {late, data}; late=1 drives data 1 ns after a main edge
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 8'h3C}, {1'b0, 8'hA5}, {1'b1, 8'h5A}, {1'b0, 8'h5A},
    {1'b1, 8'hFF}, {1'b1, 8'h00}, {1'b0, 8'h81}, {1'b0, 8'h81},
    {1'b1, 8'h81}, {1'b0, 8'h7E}, {1'b0, 8'h7E}, {1'b0, 8'h7E}
  };

  logic clk_main = 1'b0;
  logic clk_late = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] q_out;
  logic err_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  shadow_reg_check #(.WIDTH(W)) u_shadow_reg_check (
    .clk_main(clk_main), .clk_late(clk_late), .rst_n(rst_n),
    .d_in(d_in), .q_out(q_out), .err_flag(err_flag)
  );

  initial forever #2.5 clk_main = ~clk_main;
  initial begin
    #2.0;
    forever #2.5 clk_late = ~clk_late;
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle();
    @(posedge clk_main);
    #3.5;
  endtask

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] dval, prev_m, prev_s, cap_m, cap_s;
    dval = '0; prev_m = '0; prev_s = '0;
    #1;
    check(q_out == '0 && err_flag == 1'b0, "R7 reset state", {q_out[W-1:1], err_flag}, '0);
    repeat (3) @(posedge clk_main);
    #1 rst_n = 1'b1;
    repeat (3) settle();

    // R1 R2 R6: table walk with a bench-side capture model
    for (int i = 0; i < NV; i++) begin
      @(posedge clk_main);
      cap_m = dval;
      #1;
      if (VEC[i][W]) begin
        dval = VEC[i][W-1:0];
        d_in = dval;
      end
      #2.5;
      cap_s = dval;
      check(q_out == cap_m, "R1 main capture", q_out, cap_m);
      check(err_flag == (prev_m != prev_s), "R2/R6 late-arrival flag", {7'd0, err_flag}, {7'd0, prev_m != prev_s});
      prev_m = cap_m;
      prev_s = cap_s;
      if (!VEC[i][W]) begin
        dval = VEC[i][W-1:0];
        d_in = dval;
      end
    end
    settle();
    check(err_flag == 1'b0, "R6 settled", {7'd0, err_flag}, 8'd0);

    // R3: glitch straddling a main edge, gone before the delayed edge
    @(posedge clk_main);
    #4.5 d_in = 8'h7F;
    @(posedge clk_main);
    #0.5 d_in = 8'h7E;
    #3.0;
    check(q_out == 8'h7F, "R3 glitch captured by main", q_out, 8'h7F);
    check(err_flag == 1'b0, "R3 no flag yet", {7'd0, err_flag}, 8'd0);
    settle();
    check(err_flag == 1'b1, "R3 glitch flagged", {7'd0, err_flag}, 8'd1);
    settle();
    check(err_flag == 1'b0, "R6 one-cycle flag", {7'd0, err_flag}, 8'd0);

    // R4: flip in the primary register
    settle();
    force u_shadow_reg_check.main_q = 8'h6E;
    #0.5 release u_shadow_reg_check.main_q;
    #0.2;
    check(q_out == 8'h6E, "R4 flip visible", q_out, 8'h6E);
    settle();
    check(err_flag == 1'b1, "R4 main flip flagged", {7'd0, err_flag}, 8'd1);
    check(q_out == 8'h7E, "R1 recapture after flip", q_out, 8'h7E);
    settle();
    check(err_flag == 1'b0, "R6 flag drops", {7'd0, err_flag}, 8'd0);

    // R5: flip in the shadow register
    settle();
    force u_shadow_reg_check.shadow_q = 8'h7F;
    #0.5 release u_shadow_reg_check.shadow_q;
    settle();
    check(err_flag == 1'b1, "R5 shadow flip flagged", {7'd0, err_flag}, 8'd1);
    settle();
    check(err_flag == 1'b0, "R6 flag drops after shadow flip", {7'd0, err_flag}, 8'd0);

    // R7: reset with a mismatch pending
    @(posedge clk_main);
    #1 d_in = 8'h11;
    #2.0 rst_n = 1'b0;
    #0.5;
    check(q_out == '0, "R7 reset clears data", q_out, '0);
    check(err_flag == 1'b0, "R7 reset clears flag", {7'd0, err_flag}, 8'd0);
    settle();
    check(err_flag == 1'b0, "R7 pending mismatch dropped", {7'd0, err_flag}, 8'd0);

    // R8: release between main and delayed edge with live data
    @(posedge clk_main);
    #1 rst_n = 1'b1;
    #2.5;
    check(err_flag == 1'b0, "R8 released", {7'd0, err_flag}, 8'd0);
    settle();
    check(err_flag == 1'b0, "R8 first edge masked", {7'd0, err_flag}, 8'd0);
    check(q_out == 8'h11, "R1 first capture after reset", q_out, 8'h11);
    settle();
    check(err_flag == 1'b0, "R8 no false error", {7'd0, err_flag}, 8'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule